// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block decides, within the same cycle, whether one local interrupt controller is a target of an interrupt message sent between processors or over the system bus. The message arrives as two command words, a low word and a high word. The low word carries the destination mode and the shorthand code. The high word carries the 8-bit destination. A separate input says whether this unit is the one sending the message. The single output `hit` is high when this unit must take the message.

The unit holds three programmable registers behind a simple write port:

- an identity register, holding the physical unit number;
- a logical-address register, holding an 8-bit logical ID;
- an addressing-model register, selecting the flat or the cluster logical model.

Each write is captured on the clock edge and acts on `hit` from the next cycle. Routing between units, arbitration among several targets and acceptance of the interrupt all happen outside this block.

Top module: `dest_match_unit`

## Requirements
- R1: After reset the identity is the `UNIT_NUM` parameter, the logical ID is zero and the addressing model is flat (all ones). So physical destination `UNIT_NUM` hits, and every flat logical destination misses.
- R2: With shorthand 0 and destination mode 0 (physical), `hit` is high when the destination equals the identity.
- R3: A physical destination of 0xFF hits regardless of the identity.
- R4: With destination mode 1 (logical) and the flat model (model nibble 0xF), `hit` is high when the logical ID and the destination share at least one set bit.
- R5: With the cluster model (model nibble 0x0), `hit` requires two things: the upper nibbles of the logical ID and the destination are equal, and their lower nibbles share at least one set bit.
- R6: A model nibble other than 0xF or 0x0 makes every logical destination miss, while physical matching keeps working.
- R7: Shorthand code 1 (self) gives `hit` = `isSender`, whatever the destination.
- R8: Shorthand code 2 (all, including self) always hits.
- R9: Shorthand code 3 (all except self) gives `hit` = not `isSender`.
- R10: The shorthand is `cmdLo[19:18]` and the destination mode is `cmdLo[11]`. The destination is `cmdHi[31:24]`, and `cmdHi[23:0]` has no effect on `hit`.
- R11: A write with `wrSel` = 2 stores only `wrData[31:28]` as the model nibble. Bits 27:0 behave as ones, so they never affect matching.
- R12: A write with `wrSel` = 0 loads the identity from `wrData[31:24]`. A write with `wrSel` = 1 loads the logical ID from `wrData[31:24]`. The lower 24 bits are dropped in both cases.
- R13: A write changes `hit` from the cycle after the capturing edge. Registers not selected keep their values. `wrSel` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 identity, 1 logical ID, 2 model, 3 none |
| wrData | input | 32 | Write data |
| cmdLo | input | 32 | Message low word (mode bit 11, shorthand bits 19:18) |
| cmdHi | input | 32 | Message high word (destination bits 31:24) |
| isSender | input | 1 | High when this unit issued the message |
| hit | output | 1 | This unit is a target of the message |

## Verification
The assertions assume three things:

- `wrSel` and `wrData` are stable at each clock edge where `wrEn` is high.
- The command words are driven to known values whenever reset is released.
- The shorthand-based checks assume the fields in `cmdLo` are decoded from bits 19:18 and 11.

The bench changes every input shortly after a rising edge and samples `hit` on the falling edge. It issues writes one at a time through a task that holds `wrEn` for exactly one edge. Command words are always fully driven, including deliberately noisy low bits in `cmdHi`.

// File: rtl/dmatch_pkg.sv
package dmatch_pkg;

  typedef struct packed {
    logic ldIdent;
    logic ldLogical;
    logic ldModel;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    SEL_IDENT   = 2'd0,
    SEL_LOGICAL = 2'd1,
    SEL_MODEL   = 2'd2,
    SEL_SPARE   = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam int MODEL_W = 4;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/dmatch_ctrl.sv
module dmatch_ctrl
  import dmatch_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  output wrStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (regSel_e'(wrSel))
        SEL_IDENT:   strobe.ldIdent   = 1'b1;
        SEL_LOGICAL: strobe.ldLogical = 1'b1;
        SEL_MODEL:   strobe.ldModel   = 1'b1;
        default:     strobe           = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmatch_datapath.sv
module dmatch_datapath
  import dmatch_pkg::*;
#(
  parameter int          ID_W     = 8,
  parameter int          WORD_W   = 32,
  parameter int unsigned UNIT_NUM = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] cmdLo,
  input  logic [WORD_W-1:0] cmdHi,
  input  logic              isSender,
  output logic              hit
);

  localparam int ID_LSB    = WORD_W - ID_W;
  localparam int NIB       = ID_W / 2;
  localparam int MODEL_LSB = WORD_W - MODEL_W;
  localparam int SH_LSB    = 18;
  localparam int DM_BIT    = 11;
  localparam logic [ID_W-1:0] RESET_ID = ID_W'(UNIT_NUM);

  logic [ID_W-1:0]    identReg;
  logic [ID_W-1:0]    logicReg;
  logic [MODEL_W-1:0] modelReg;

  // Register file: only the upper field of each write is kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      identReg <= RESET_ID;
      logicReg <= '0;
      modelReg <= MODEL_FLAT;
    end else begin
      if (strobe.ldIdent)   identReg <= wrData[WORD_W-1:ID_LSB];
      if (strobe.ldLogical) logicReg <= wrData[WORD_W-1:ID_LSB];
      if (strobe.ldModel)   modelReg <= wrData[WORD_W-1:MODEL_LSB];
    end
  end

  // Field extraction from the message words
  logic [ID_W-1:0] destId;
  logic            logicalMode;
  shorthand_e      sh;

  assign destId      = cmdHi[WORD_W-1:ID_LSB];
  assign logicalMode = cmdLo[DM_BIT];
  assign sh          = shorthand_e'(cmdLo[SH_LSB +: 2]);

  // Address comparison
  logic physHit, flatHit, clusterHit, logHit, addrHit;

  assign physHit    = (destId == '1) || (destId == identReg);
  assign flatHit    = |(logicReg & destId);
  assign clusterHit = (logicReg[ID_W-1:NIB] == destId[ID_W-1:NIB]) &&
                      (|(logicReg[NIB-1:0] & destId[NIB-1:0]));

  always_comb begin
    unique case (modelReg)
      MODEL_FLAT:    logHit = flatHit;
      MODEL_CLUSTER: logHit = clusterHit;
      default:       logHit = 1'b0;
    endcase
  end

  assign addrHit = logicalMode ? logHit : physHit;

  always_comb begin
    unique case (sh)
      SH_NONE:   hit = addrHit;
      SH_SELF:   hit = isSender;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !isSender;
      default:   hit = 1'b0;
    endcase
  end

  // R12: identity register picks up the upper byte of the write
  a_r12_ident_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldIdent |=> identReg == $past(wrData[WORD_W-1:ID_LSB]));

  // R13: no strobe, no register change
  a_r13_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ldIdent || strobe.ldLogical || strobe.ldModel)
      |=> ($stable(identReg) && $stable(logicReg) && $stable(modelReg)));

  // R3: physical broadcast always reaches this unit
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLo[SH_LSB +: 2] == 2'd0 && !cmdLo[DM_BIT] && cmdHi[WORD_W-1:ID_LSB] == '1) |-> hit);

  // R8: all-including shorthand always hits
  a_r8_all_incl: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLo[SH_LSB +: 2] == 2'd2) |-> hit);

  // R9: all-but-self never reaches the sender
  a_r9_excl_self: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLo[SH_LSB +: 2] == 2'd3 && isSender) |-> !hit);

endmodule

// File: rtl/dest_match_unit.sv
module dest_match_unit
  import dmatch_pkg::*;
#(
  parameter int          ID_W     = 8,
  parameter int          WORD_W   = 32,
  parameter int unsigned UNIT_NUM = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] cmdLo,
  input  logic [WORD_W-1:0] cmdHi,
  input  logic              isSender,
  output logic              hit
);

  wrStrobe_t strobe;

  dmatch_ctrl ctrl_i (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .strobe (strobe)
  );

  dmatch_datapath #(
    .ID_W     (ID_W),
    .WORD_W   (WORD_W),
    .UNIT_NUM (UNIT_NUM)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .cmdLo    (cmdLo),
    .cmdHi    (cmdHi),
    .isSender (isSender),
    .hit      (hit)
  );

endmodule

// File: tb/dest_match_unit_tb_top.sv
module dest_match_unit_tb_top;

  localparam int unsigned UNIT = 5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrSel;
  logic [31:0] wrData;
  logic [31:0] cmdLo;
  logic [31:0] cmdHi;
  logic        isSender;
  logic        hit;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sbq[$];

  // independent reference state, updated by the write task
  logic [7:0] mIdent;
  logic [7:0] mLogic;
  logic [3:0] mModel;

  always #5 clk = ~clk;

  dest_match_unit #(.UNIT_NUM(UNIT)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .cmdLo(cmdLo), .cmdHi(cmdHi), .isSender(isSender), .hit(hit)
  );

  function automatic logic [31:0] mkLo(input logic logical, input logic [1:0] sh);
    mkLo = 32'h0;
    mkLo[11] = logical;
    mkLo[19:18] = sh;
  endfunction

  function automatic logic expect_hit(input logic [31:0] lo, input logic [31:0] hi,
                                      input logic snd);
    logic [7:0] d;
    logic       lg;
    d  = hi[31:24];
    lg = lo[11];
    case (lo[19:18])
      2'd1: return snd;
      2'd2: return 1'b1;
      2'd3: return !snd;
      default: begin
        if (!lg) return (d == 8'hFF) || (d == mIdent);
        if (mModel == 4'hF) return (mLogic & d) != 8'h0;
        if (mModel == 4'h0)
          return (mLogic[7:4] == d[7:4]) && ((mLogic[3:0] & d[3:0]) != 4'h0);
        return 1'b0;
      end
    endcase
  endfunction

  task automatic do_write(input logic [1:0] sel, input logic [31:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
    case (sel)
      2'd0: mIdent = data[31:24];
      2'd1: mLogic = data[31:24];
      2'd2: mModel = data[31:28];
      default: ;
    endcase
  endtask

  task automatic drive(input logic [31:0] lo, input logic [31:0] hi,
                       input logic snd, input string tag);
    item_t it;
    @(posedge clk); #1;
    cmdLo = lo; cmdHi = hi; isSender = snd;
    it.exp = expect_hit(lo, hi, snd);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (hit !== it.exp) begin
          failures++;
          $display("FAIL %s hit=%0b expected=%0b", it.tag, hit, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired hit=%0b expected=done", hit);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = 2'd0; wrData = '0;
    cmdLo = '0; cmdHi = '0; isSender = 1'b0;
    mIdent = 8'(UNIT); mLogic = 8'h00; mModel = 4'hF;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    drive(mkLo(0, 0), {8'h05, 24'h0}, 0, "R1 reset identity");
    drive(mkLo(0, 0), {8'h06, 24'h0}, 0, "R1 other id misses");
    drive(mkLo(1, 0), {8'hFF, 24'h0}, 0, "R1 logical id cleared");

    // R2 / R12 identity write with noisy low bits
    do_write(2'd0, 32'h2A12_3456);
    drive(mkLo(0, 0), {8'h2A, 24'h0}, 0, "R2 physical equal id");
    drive(mkLo(0, 0), {8'h05, 24'h0}, 0, "R13 old id no longer hits");
    drive(mkLo(0, 0), {8'h12, 24'h0}, 0, "R12 low write bits dropped");

    // R3 broadcast
    drive(mkLo(0, 0), {8'hFF, 24'h0}, 0, "R3 physical broadcast");

    // R10 field positions
    drive(mkLo(0, 0), {8'h2A, 24'hFFFFFF}, 0, "R10 high word low bits ignored");
    drive(mkLo(0, 0), {8'h2B, 24'h00002A}, 0, "R10 dest from bits 31:24");

    // R4 flat logical
    do_write(2'd1, 32'h2400_FFFF);
    drive(mkLo(1, 0), {8'h04, 24'h0}, 0, "R4 flat overlap low");
    drive(mkLo(1, 0), {8'h20, 24'h0}, 0, "R4 flat overlap high");
    drive(mkLo(1, 0), {8'hDB, 24'h0}, 0, "R4 flat no overlap");
    drive(mkLo(1, 0), {8'h2A, 24'h0}, 0, "R10 mode bit selects logical");

    // R5 cluster (write 0 -> forced 0x0FFFFFFF, model nibble 0)
    do_write(2'd2, 32'h0000_0000);
    drive(mkLo(1, 0), {8'h26, 24'h0}, 0, "R5 cluster match");
    drive(mkLo(1, 0), {8'h34, 24'h0}, 0, "R5 cluster id differs");
    drive(mkLo(1, 0), {8'h2B, 24'h0}, 0, "R5 cluster no member overlap");

    // R6 invalid model
    do_write(2'd2, 32'h5000_0000);
    drive(mkLo(1, 0), {8'h24, 24'h0}, 0, "R6 bad model logical miss");
    drive(mkLo(1, 0), {8'hFF, 24'h0}, 0, "R6 bad model broadcast logical miss");
    drive(mkLo(0, 0), {8'h2A, 24'h0}, 0, "R6 physical still works");

    // R11 only top nibble of model write matters
    do_write(2'd2, 32'hF000_0000);
    drive(mkLo(1, 0), {8'h20, 24'h0}, 0, "R11 flat restored");
    do_write(2'd2, 32'h0ABC_DEF0);
    drive(mkLo(1, 0), {8'h20, 24'h0}, 0, "R11 low bits give cluster");
    drive(mkLo(1, 0), {8'h24, 24'h0}, 0, "R11 cluster active");
    do_write(2'd2, 32'hF000_0000);

    // R7 self
    drive(mkLo(0, 1), {8'h77, 24'h0}, 1, "R7 self sender");
    drive(mkLo(1, 1), {8'h24, 24'h0}, 0, "R7 self non sender");

    // R8 all including self
    drive(mkLo(0, 2), {8'h00, 24'h0}, 0, "R8 all non sender");
    drive(mkLo(1, 2), {8'h00, 24'h0}, 1, "R8 all sender");

    // R9 all but self
    drive(mkLo(0, 3), {8'h2A, 24'h0}, 1, "R9 excl sender");
    drive(mkLo(0, 3), {8'h00, 24'h0}, 0, "R9 excl non sender");

    // R13 spare select writes nothing
    do_write(2'd3, 32'h0000_0000);
    drive(mkLo(0, 0), {8'h2A, 24'h0}, 0, "R13 spare keeps identity");
    drive(mkLo(1, 0), {8'h04, 24'h0}, 0, "R13 spare keeps logical and model");

    // R13 logical write leaves identity alone
    do_write(2'd1, 32'h8100_0000);
    drive(mkLo(0, 0), {8'h2A, 24'h0}, 0, "R13 identity untouched");
    drive(mkLo(1, 0), {8'h01, 24'h0}, 0, "R12 logical upper byte loaded");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule